// File: doc/BRIEF.md
# SMBus Alert Notification and Alert-Response Responder

This block is the slave-side notification logic of a sideband network controller. It collects notification events (a LAN packet for the manager, a status request, a status change when status notification is on) and, when the notify method is set to alert, pulls a shared open-drain alert line low. The management controller then either runs an Alert Response Address (ARA) cycle or sends a read command straight to the device's own address. The alert is withdrawn at the protocol point that matches the path the master took. A hardware timeout, set from non-volatile configuration with no software access, also ends an unanswered alert.

The block sits behind a byte-level SMBus slave front end. The front end reports START and STOP as pulses. It presents each address byte and each command byte for a combinational acknowledge, and it requests read bytes, which the block supplies in the same cycle. Bit-level serialisation, PEC and message payload storage live elsewhere. The reply to a read command is a fixed status byte parameter.

Top module: `smb_alert_resp`

## Requirements
- R1: The alert output enable `alert_oe_o` (1 = pull line low) rises on the clock edge that samples an event only while `notify_mode_i` is 2'd0 (alert mode). An event seen in another mode is held pending and raises the alert on the first edge that finds alert mode selected.
- R2: A status-change event is ignored unless `stat_notify_en_i` is 1. LAN and status-request events are never gated.
- R3: An address byte of 8'h19 (7-bit address 7'h0C with read bit 1) is acknowledged only while the alert is asserted. Otherwise it is not acknowledged.
- R4: During a read request in an acknowledged ARA cycle, `rd_data_o` is the own 7-bit address in bits 7:1 with bit 0 = 0. No further byte is implied.
- R5: After an acknowledged ARA cycle the alert stays asserted through the data byte and clears on the edge that samples STOP.
- R6: An address byte whose bits 7:1 equal `own_addr_i` is always acknowledged. A command byte after an own-address write is always acknowledged. A read request after an own-address read returns the parameter STATUS_BYTE, with or without a pending alert.
- R7: A command byte of 8'hC0, 8'hD0 or 8'hDE after an own-address write clears an asserted alert on the edge that samples the command byte. Any other code leaves the alert unchanged.
- R8: With `tmo_limit_i` = L > 0, an alert left unanswered clears exactly L×TICK_DIV cycles after it rose, and the count restarts at every new assertion. L = 0 disables the timeout.
- R9: Events that arrive while the alert is asserted are latched. The alert is raised again on the edge after the one that cleared it.
- R10: An address byte that is neither the ARA byte nor the own address is not acknowledged, and a later read request returns 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| own_addr_i | input | 7 | Own 7-bit slave address |
| notify_mode_i | input | 2 | Notify method: 0 alert, 1 async notify, 2 direct receive |
| tmo_limit_i | input | TMO_W | Alert timeout in prescaled ticks, 0 = off |
| stat_notify_en_i | input | 1 | Enables status-change events |
| evt_lan_i | input | 1 | Pulse: LAN packet for manager received |
| evt_stat_req_i | input | 1 | Pulse: status request received |
| evt_stat_chg_i | input | 1 | Pulse: link/status change |
| start_i | input | 1 | Pulse: START or repeated START seen |
| stop_i | input | 1 | Pulse: STOP seen |
| addr_vld_i | input | 1 | Address byte valid |
| addr_byte_i | input | 8 | Address byte, read/write in bit 0 |
| addr_ack_o | output | 1 | Acknowledge for address byte |
| cmd_vld_i | input | 1 | Command byte valid |
| cmd_byte_i | input | 8 | Command byte |
| cmd_ack_o | output | 1 | Acknowledge for command byte |
| rd_req_i | input | 1 | Front end requests a read byte |
| rd_data_o | output | 8 | Read byte, valid with rd_req_i |
| alert_oe_o | output | 1 | Open-drain alert pull-down enable |

## Verification
The hardest case to reach is an event that lands while an alert is already asserted. The latched event must not be lost when the ARA STOP clears the line, and it must re-raise the alert one edge later with a fresh timeout. The bench raises an alert, injects a status request mid-alert, completes an ARA cycle, and samples the line on the STOP edge and on the edge after it. A table of command codes, read and non-read, is walked with an alert raised each time, so that only the three read codes withdraw it at the command byte. A short prescaler divider makes the timeout boundary observable cycle by cycle.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  typedef enum logic [1:0] {
    NOTIFY_ALERT  = 2'd0,
    NOTIFY_ASYNC  = 2'd1,
    NOTIFY_DIRECT = 2'd2
  } notify_mode_e;

  localparam logic [6:0] ARA_ADDR = 7'h0C;
  localparam logic [7:0] ARA_BYTE = {ARA_ADDR, 1'b1};

  function automatic logic is_rd_cmd(input logic [7:0] code);
    return (code == 8'hC0) || (code == 8'hD0) || (code == 8'hDE);
  endfunction
endpackage

// File: rtl/smb_alert_evt.sv
module smb_alert_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alert_mode_i,
  input  logic stat_notify_en_i,
  input  logic evt_lan_i,
  input  logic evt_stat_req_i,
  input  logic evt_stat_chg_i,
  input  logic clr_i,
  output logic alert_o,
  output logic pending_o
);
  logic alert_q, pending_q, evt_any;

  assign evt_any = evt_lan_i | evt_stat_req_i | (evt_stat_chg_i & stat_notify_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alert_q   <= 1'b0;
      pending_q <= 1'b0;
    end else if (alert_q) begin
      if (clr_i)   alert_q   <= 1'b0;
      if (evt_any) pending_q <= 1'b1;
    end else if (alert_mode_i && (pending_q || evt_any)) begin
      alert_q   <= 1'b1;
      pending_q <= 1'b0;
    end else if (evt_any) begin
      pending_q <= 1'b1;
    end
  end

  assign alert_o   = alert_q;
  assign pending_o = pending_q;

  // R9
  realert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_q && pending_q && alert_mode_i) |=> alert_q);
endmodule

// File: rtl/smb_alert_tmo.sv
module smb_alert_tmo #(
  parameter int unsigned TICK_DIV = 125000,
  parameter int unsigned TMO_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alert_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [TMO_W-1:0] tcnt_q;
  logic             tick;

  assign tick = alert_i && (pre_q == PRE_W'(TICK_DIV - 1));

  // counters held clear while idle so each new alert starts a full window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tcnt_q <= '0;
    end else if (!alert_i) begin
      pre_q  <= '0;
      tcnt_q <= '0;
    end else if (tick) begin
      pre_q  <= '0;
      tcnt_q <= tcnt_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  assign expire_o = tick && (limit_i != '0) && (tcnt_q == limit_i - 1'b1);

  // R8
  tmo_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_i) |-> (tcnt_q == '0 && pre_q == '0));
endmodule

// File: rtl/smb_alert_xact.sv
module smb_alert_xact #(
  parameter logic [7:0] STATUS_BYTE = 8'h5A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [6:0] own_addr_i,
  input  logic       alert_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       addr_vld_i,
  input  logic [7:0] addr_byte_i,
  output logic       addr_ack_o,
  input  logic       cmd_vld_i,
  input  logic [7:0] cmd_byte_i,
  output logic       cmd_ack_o,
  input  logic       rd_req_i,
  output logic [7:0] rd_data_o,
  output logic       clr_ara_o,
  output logic       clr_cmd_o
);
  import smb_alert_pkg::*;

  logic ara_q, own_wr_q, own_rd_q;
  logic is_ara, is_own;

  assign is_ara = (addr_byte_i == ARA_BYTE);
  assign is_own = (addr_byte_i[7:1] == own_addr_i) && !is_ara;

  assign addr_ack_o = addr_vld_i && ((is_ara && alert_i) || is_own);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ara_q    <= 1'b0;
      own_wr_q <= 1'b0;
      own_rd_q <= 1'b0;
    end else if (start_i || stop_i) begin
      ara_q    <= 1'b0;
      own_wr_q <= 1'b0;
      own_rd_q <= 1'b0;
    end else if (addr_vld_i) begin
      ara_q    <= is_ara && alert_i;
      own_wr_q <= is_own && !addr_byte_i[0];
      own_rd_q <= is_own && addr_byte_i[0];
    end
  end

  assign cmd_ack_o = cmd_vld_i && own_wr_q;
  assign clr_cmd_o = cmd_ack_o && is_rd_cmd(cmd_byte_i) && alert_i;
  assign clr_ara_o = stop_i && ara_q;

  always_comb begin
    if (!rd_req_i)     rd_data_o = 8'h00;
    else if (ara_q)    rd_data_o = {own_addr_i, 1'b0};
    else if (own_rd_q) rd_data_o = STATUS_BYTE;
    else               rd_data_o = 8'hFF;
  end

  // R6
  sess_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ara_q, own_wr_q, own_rd_q}) <= 1);
endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp #(
  parameter int unsigned TICK_DIV    = 125000,
  parameter int unsigned TMO_W       = 8,
  parameter logic [7:0]  STATUS_BYTE = 8'h5A
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [6:0]       own_addr_i,
  input  logic [1:0]       notify_mode_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             stat_notify_en_i,
  input  logic             evt_lan_i,
  input  logic             evt_stat_req_i,
  input  logic             evt_stat_chg_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             addr_vld_i,
  input  logic [7:0]       addr_byte_i,
  output logic             addr_ack_o,
  input  logic             cmd_vld_i,
  input  logic [7:0]       cmd_byte_i,
  output logic             cmd_ack_o,
  input  logic             rd_req_i,
  output logic [7:0]       rd_data_o,
  output logic             alert_oe_o
);
  import smb_alert_pkg::*;

  logic alert, pending, clr_ara, clr_cmd, expire, alert_mode;

  assign alert_mode = (notify_mode_i == NOTIFY_ALERT);

  smb_alert_evt u_evt (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .alert_mode_i     (alert_mode),
    .stat_notify_en_i (stat_notify_en_i),
    .evt_lan_i        (evt_lan_i),
    .evt_stat_req_i   (evt_stat_req_i),
    .evt_stat_chg_i   (evt_stat_chg_i),
    .clr_i            (clr_ara | clr_cmd | expire),
    .alert_o          (alert),
    .pending_o        (pending)
  );

  smb_alert_tmo #(.TICK_DIV(TICK_DIV), .TMO_W(TMO_W)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alert_i  (alert),
    .limit_i  (tmo_limit_i),
    .expire_o (expire)
  );

  smb_alert_xact #(.STATUS_BYTE(STATUS_BYTE)) u_xact (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .own_addr_i  (own_addr_i),
    .alert_i     (alert),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .addr_vld_i  (addr_vld_i),
    .addr_byte_i (addr_byte_i),
    .addr_ack_o  (addr_ack_o),
    .cmd_vld_i   (cmd_vld_i),
    .cmd_byte_i  (cmd_byte_i),
    .cmd_ack_o   (cmd_ack_o),
    .rd_req_i    (rd_req_i),
    .rd_data_o   (rd_data_o),
    .clr_ara_o   (clr_ara),
    .clr_cmd_o   (clr_cmd)
  );

  assign alert_oe_o = alert;

  // R1
  rise_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_oe_o) |-> $past(notify_mode_i) == NOTIFY_ALERT);
  // R3
  ara_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && addr_byte_i == ARA_BYTE && addr_ack_o) |-> alert_oe_o);
  // R5
  ara_stop_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ara |=> !alert_oe_o);
  // R7
  cmd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> !alert_oe_o);
  // R8
  tmo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> !alert_oe_o);
  // R9
  hold_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_oe_o && pending) |=> (alert_oe_o || pending));
endmodule

// File: tb/smb_alert_resp_tb.sv
module smb_alert_resp_tb;
  localparam int unsigned DIV = 4;
  localparam logic [7:0] STAT = 8'h5A;
  localparam logic [6:0] OWN  = 7'h49;
  localparam logic [7:0] OWN_W = {OWN, 1'b0};
  localparam logic [7:0] OWN_R = {OWN, 1'b1};
  localparam logic [7:0] ARA_B = 8'h19;

  // {expect_clear, command code}
  localparam logic [8:0] CMD_TAB [6] = '{
    {1'b1, 8'hC0}, {1'b1, 8'hD0}, {1'b1, 8'hDE},
    {1'b0, 8'hC1}, {1'b0, 8'h00}, {1'b0, 8'hDF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] tmo = 8'd0;
  logic en = 1'b1, e_lan = 1'b0, e_req = 1'b0, e_chg = 1'b0;
  logic start = 1'b0, stop = 1'b0, avld = 1'b0, cvld = 1'b0, rreq = 1'b0;
  logic [7:0] abyte = 8'h00, cbyte = 8'h00;
  logic aack, cack, alert;
  logic [7:0] rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  smb_alert_resp #(.TICK_DIV(DIV), .TMO_W(8), .STATUS_BYTE(STAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .own_addr_i(OWN), .notify_mode_i(mode),
    .tmo_limit_i(tmo), .stat_notify_en_i(en), .evt_lan_i(e_lan),
    .evt_stat_req_i(e_req), .evt_stat_chg_i(e_chg), .start_i(start),
    .stop_i(stop), .addr_vld_i(avld), .addr_byte_i(abyte), .addr_ack_o(aack),
    .cmd_vld_i(cvld), .cmd_byte_i(cbyte), .cmd_ack_o(cack), .rd_req_i(rreq),
    .rd_data_o(rdata), .alert_oe_o(alert)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic p_start; start = 1; @(negedge clk); start = 0; endtask
  task automatic p_stop;  stop  = 1; @(negedge clk); stop  = 0; endtask

  task automatic addr_ph(input logic [7:0] b, output logic ack);
    avld = 1; abyte = b; #1 ack = aack; @(negedge clk); avld = 0;
  endtask

  task automatic cmd_ph(input logic [7:0] b, output logic ack);
    cvld = 1; cbyte = b; #1 ack = cack; @(negedge clk); cvld = 0;
  endtask

  task automatic rd_ph(output logic [7:0] d);
    rreq = 1; #1 d = rdata; @(negedge clk); rreq = 0;
  endtask

  task automatic raise_lan;
    e_lan = 1; @(negedge clk); e_lan = 0;
  endtask

  task automatic ara(output logic ack, output logic [7:0] d);
    p_start; addr_ph(ARA_B, ack); rd_ph(d); p_stop;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    cyc(2);
    chk("R1 reset alert", {7'd0, alert}, 8'd0);
    rst_n = 1;
    cyc(1);

    // R3 / R10: decode with no alert
    p_start; addr_ph(ARA_B, ack); chk("R3 ara nack idle", {7'd0, ack}, 8'd0); p_stop;
    p_start; addr_ph(8'h34, ack); chk("R10 foreign nack", {7'd0, ack}, 8'd0);
    rd_ph(d); chk("R10 foreign read", d, 8'hFF); p_stop;
    // R6: status read with no alert
    p_start; addr_ph(OWN_R, ack); chk("R6 own ack idle", {7'd0, ack}, 8'd1);
    rd_ph(d); chk("R6 status idle", d, STAT); p_stop;

    // R1: raise on event edge
    raise_lan;
    chk("R1 alert raised", {7'd0, alert}, 8'd1);
    // R3/R4/R5: ARA cycle
    p_start; addr_ph(ARA_B, ack); chk("R3 ara ack", {7'd0, ack}, 8'd1);
    rd_ph(d); chk("R4 ara data", d, OWN_W);
    chk("R5 held through data", {7'd0, alert}, 8'd1);
    p_stop; chk("R5 clear at stop", {7'd0, alert}, 8'd0);
    cyc(3); chk("R5 stays clear", {7'd0, alert}, 8'd0);

    // R7: command table
    for (int i = 0; i < 6; i++) begin
      raise_lan;
      p_start; addr_ph(OWN_W, ack); chk("R6 own write ack", {7'd0, ack}, 8'd1);
      cmd_ph(CMD_TAB[i][7:0], ack); chk("R6 cmd ack", {7'd0, ack}, 8'd1);
      chk("R7 alert after cmd", {7'd0, alert}, {7'd0, ~CMD_TAB[i][8]});
      p_start; addr_ph(OWN_R, ack); rd_ph(d); chk("R6 status reply", d, STAT); p_stop;
      if (alert) begin ara(ack, d); end
      chk("R7 cleared", {7'd0, alert}, 8'd0);
    end

    // R2: status change gating
    en = 0; e_chg = 1; cyc(1); e_chg = 0; cyc(3);
    chk("R2 chg ignored", {7'd0, alert}, 8'd0);
    en = 1; e_chg = 1; cyc(1); e_chg = 0;
    chk("R2 chg enabled", {7'd0, alert}, 8'd1);
    ara(ack, d);

    // R1: pending in non-alert mode
    mode = 2'd1; raise_lan; cyc(3);
    chk("R1 no alert async mode", {7'd0, alert}, 8'd0);
    mode = 2'd0; cyc(1);
    chk("R1 pending raises", {7'd0, alert}, 8'd1);
    ara(ack, d);

    // R9: event during alert
    raise_lan;
    e_req = 1; cyc(1); e_req = 0;
    p_start; addr_ph(ARA_B, ack); rd_ph(d); p_stop;
    chk("R9 cleared at stop", {7'd0, alert}, 8'd0);
    cyc(1);
    chk("R9 re-raised", {7'd0, alert}, 8'd1);
    ara(ack, d);
    cyc(2); chk("R9 none left", {7'd0, alert}, 8'd0);

    // R8: timeout 3 ticks x DIV
    tmo = 8'd3;
    raise_lan;
    cyc(3 * DIV - 1);
    chk("R8 before expiry", {7'd0, alert}, 8'd1);
    cyc(1);
    chk("R8 expired", {7'd0, alert}, 8'd0);
    tmo = 8'd0;
    raise_lan; cyc(10 * DIV);
    chk("R8 zero disables", {7'd0, alert}, 8'd1);
    ara(ack, d);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule